// File: doc/BRIEF.md
# Clock Gear Divider with Clock Output

This block derives a gear-scaled system clock from a fast reference clock. Every modelled clock is a single-cycle enable pulse on the reference clock `clk`. The base for gearing is either the reference clock itself, with one base tick per cycle, or an externally supplied slow tick `slow_tick`. A three-bit gear code divides the base by 1, 2, 4, 8 or 16 to form the geared tick. The system tick always runs at half the geared rate.

Software writes a new gear setting through a small write-only register port. The setting is held as pending and is applied only when the system-period counter wraps, so a divided period that is under way always completes at its old length. A second register routes the slow tick or the system tick to a square-wave clock output pin. In the deeper halt modes that pin is frozen at its present level.

Top module: `clkgear_unit`

## Requirements
- R1: After reset the gear code is 0 and the source is the reference clock, `gear_pending` is 0 and `clk_out` is 0. With no writes, `sys_tick` pulses once every 2 cycles and `gear_tick` pulses every cycle.
- R2: Bit 3 of a write to the control register (address 0xE1) selects the gearing base. A 0 selects the reference clock (one base tick per cycle) and a 1 selects `slow_tick` pulses.
- R3: Bits [2:0] of a control write form the gear code n, where n is 0 to 4. Once n is applied, `gear_tick` pulses once every 2^n base ticks.
- R4: `sys_tick` pulses once every 2^(n+1) base ticks. Every `sys_tick` pulse coincides with a `gear_tick` pulse, and `sys_tick` never pulses in two consecutive cycles.
- R5: A new setting takes effect only at the wrap of the system-period counter. The period running at the time of the write completes at its old length, and the period after the wrap uses the new length.
- R6: `gear_pending` reads 1 from the cycle after a control write until the wrap that applies the setting. It then reads 0 in the same cycle as that wrap's `sys_tick`.
- R7: Gear codes 5, 6 and 7 are reserved. Writing one leaves the gear selection as it was before the write.
- R8: Bits [7:4] of a control write have no effect on the gear or the source.
- R9: A write to the pin register (address 0xE2) sets the pin enable from bit 1 and the pin select from bit 0. While the pin is disabled, `clk_out` is 0.
- R10: With the pin enabled and in a running mode, `clk_out` toggles on every `slow_tick` when select is 0. It toggles on every `sys_tick` when select is 1.
- R11: `pwr_mode` 00 is run and 01 is light halt; in both, the clock output keeps toggling. With `pwr_mode` 10 or 11 (deep halt), `clk_out` holds its present level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle pulse marking each slow clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pwr_mode | input | 2 | Power mode: 00 run, 01 light halt, 1x deep halt |
| gear_tick | output | 1 | Geared clock enable pulse |
| sys_tick | output | 1 | System clock enable pulse at half the geared rate |
| gear_pending | output | 1 | A written gear/source setting is waiting for the wrap |
| clk_out | output | 1 | Clock output pin level |

## Verification
Several properties are checked on every cycle:
- The active gear code never holds a reserved value.
- The active gear changes only in the cycle after a counter wrap.
- `gear_pending` falls only on a wrap.
- `sys_tick` is isolated and always accompanied by `gear_tick`.
- A frozen or disabled pin does not move.

Only the bench's scenarios can show the actual pulse rates for each gear code and source. They also show that the period in flight at a write keeps its old length, that the pin toggle counts match the selected source, and that reserved codes and upper data bits leave the rate untouched.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;
  localparam int GEAR_W   = 3;
  localparam int MAX_GEAR = 4;
  localparam int CNT_W    = MAX_GEAR + 1;

  typedef logic [GEAR_W-1:0] gear_t;
  typedef logic [CNT_W-1:0]  gcnt_t;

  // a code names a usable ratio only up to MAX_GEAR
  function automatic logic gear_code_ok(input gear_t code);
    return code <= gear_t'(MAX_GEAR);
  endfunction

  // last counter value of one system period (2 << g base ticks)
  function automatic gcnt_t sys_last(input gear_t g);
    logic [CNT_W:0] span;
    span = {{CNT_W{1'b0}}, 1'b1} << (g + gear_t'(1));
    span = span - {{CNT_W{1'b0}}, 1'b1};
    return span[CNT_W-1:0];
  endfunction

  // low-bit mask marking the end of one geared period (1 << g base ticks)
  function automatic gcnt_t gear_mask(input gear_t g);
    logic [CNT_W:0] span;
    span = {{CNT_W{1'b0}}, 1'b1} << g;
    span = span - {{CNT_W{1'b0}}, 1'b1};
    return span[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/clkgear_regs.sv
module clkgear_regs
  import clkgear_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE1,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 8'hE2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wrap,
  output gear_t             pend_gear,
  output logic              pend_src,
  output logic              pending,
  output logic              pin_en,
  output logic              pin_sel
);
  localparam int SRC_BIT = GEAR_W;

  logic  ctrl_wr;
  logic  pin_wr;
  gear_t wr_code;
  logic  code_ok;

  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign pin_wr  = wr_en && (wr_addr == PIN_ADDR);
  assign wr_code = wr_data[GEAR_W-1:0];
  assign code_ok = gear_code_ok(wr_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_gear <= '0;
      pend_src  <= 1'b0;
      pending   <= 1'b0;
    end else if (ctrl_wr) begin
      pend_src <= wr_data[SRC_BIT];
      if (code_ok) pend_gear <= wr_code;
      pending <= 1'b1;
    end else if (wrap) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en  <= 1'b0;
      pin_sel <= 1'b0;
    end else if (pin_wr) begin
      pin_sel <= wr_data[0];
      pin_en  <= wr_data[1];
    end
  end

  // R6
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(wrap));
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> pending);
  // R7
  rsvd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !code_ok) |=> $stable(pend_gear));
endmodule

// File: rtl/clkgear_div.sv
module clkgear_div
  import clkgear_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slow_tick,
  input  gear_t pend_gear,
  input  logic  pend_src,
  input  logic  pending,
  output logic  wrap,
  output logic  gear_tick,
  output logic  sys_tick
);
  gcnt_t cnt;
  gear_t act_gear;
  logic  act_src;
  logic  base_tick;
  logic  at_last;
  logic  gear_hit;
  gcnt_t mask;

  assign base_tick = act_src ? slow_tick : 1'b1;
  assign at_last   = (cnt == sys_last(act_gear));
  assign wrap      = base_tick && at_last;
  assign mask      = gear_mask(act_gear);
  assign gear_hit  = base_tick && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_gear  <= '0;
      act_src   <= 1'b0;
      gear_tick <= 1'b0;
      sys_tick  <= 1'b0;
    end else begin
      gear_tick <= gear_hit;
      sys_tick  <= wrap;
      if (wrap) begin
        cnt <= '0;
        if (pending) begin
          act_gear <= pend_gear;
          act_src  <= pend_src;
        end
      end else if (base_tick) begin
        cnt <= cnt + gcnt_t'(1);
      end
    end
  end

  // R7
  act_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gear_code_ok(act_gear));
  // R5
  change_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_gear) |-> $past(wrap));
  // R4
  sys_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick);
  // R4
  sys_with_gear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |-> gear_tick);
endmodule

// File: rtl/clkgear_pin.sv
module clkgear_pin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       sys_tick,
  input  logic       pin_en,
  input  logic       pin_sel,
  input  logic [1:0] pwr_mode,
  output logic       clk_out
);
  logic deep;
  logic edge_src;

  assign deep     = (pwr_mode == 2'b10) || (pwr_mode == 2'b11);
  assign edge_src = pin_sel ? sys_tick : slow_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clk_out <= 1'b0;
    else if (!pin_en)  clk_out <= 1'b0;
    else if (deep)     clk_out <= clk_out;
    else if (edge_src) clk_out <= ~clk_out;
  end

  // R11
  deep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && deep) |=> (!pin_en || $stable(clk_out)));
  // R9
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=> !clk_out);
endmodule

// File: rtl/clkgear_unit.sv
module clkgear_unit
  import clkgear_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE1,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 8'hE2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        pwr_mode,
  output logic              gear_tick,
  output logic              sys_tick,
  output logic              gear_pending,
  output logic              clk_out
);
  gear_t pend_gear;
  logic  pend_src;
  logic  wrap;
  logic  pin_en;
  logic  pin_sel;

  clkgear_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .PIN_ADDR(PIN_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wrap(wrap), .pend_gear(pend_gear),
    .pend_src(pend_src), .pending(gear_pending),
    .pin_en(pin_en), .pin_sel(pin_sel)
  );

  clkgear_div u_div (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .pend_gear(pend_gear), .pend_src(pend_src), .pending(gear_pending),
    .wrap(wrap), .gear_tick(gear_tick), .sys_tick(sys_tick)
  );

  clkgear_pin u_pin (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
    .pin_en(pin_en), .pin_sel(pin_sel), .pwr_mode(pwr_mode),
    .clk_out(clk_out)
  );
endmodule

// File: tb/clkgear_unit_bench.sv
`timescale 1ns/1ps
module clkgear_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] pwr_mode = 2'b00;
  logic       gear_tick, sys_tick, gear_pending, clk_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [7:0] CTRL = 8'hE1;
  localparam logic [7:0] PINR = 8'hE2;
  localparam int SLOW_DIV = 3;

  clkgear_unit u_clkgear_unit (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwr_mode(pwr_mode),
    .gear_tick(gear_tick), .sys_tick(sys_tick),
    .gear_pending(gear_pending), .clk_out(clk_out)
  );

  always #5 clk = ~clk;

  // slow clock: one pulse every SLOW_DIV reference cycles
  int slow_cnt = 0;
  always @(negedge clk) begin
    slow_cnt  <= (slow_cnt == SLOW_DIV - 1) ? 0 : slow_cnt + 1;
    slow_tick <= (slow_cnt == SLOW_DIV - 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_apply();
    for (int i = 0; i < 2000 && gear_pending; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic count_win(input int n, output int s, output int g, output int t);
    logic prev;
    s = 0; g = 0; t = 0;
    prev = clk_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_tick) s++;
      if (gear_tick) g++;
      if (clk_out != prev) t++;
      prev = clk_out;
    end
  endtask

  task automatic t_reset();
    int s, g, t;
    check(gear_pending == 1'b0, "R1 pending", gear_pending, 0);
    check(clk_out == 1'b0, "R1 pin", clk_out, 0);
    count_win(64, s, g, t);
    check(s == 32, "R1 sys rate", s, 32);
    check(g == 64, "R1 gear rate", g, 64);
  endtask

  task automatic t_gear_rates();
    int s, g, t;
    for (int n = 0; n <= 4; n++) begin
      wr(CTRL, 8'(n));
      wait_apply();
      count_win(320, s, g, t);
      check(g == 320 >> n, $sformatf("R3 gear code %0d", n), g, 320 >> n);
      check(s == 320 >> (n + 1), $sformatf("R4 sys code %0d", n), s, 320 >> (n + 1));
    end
  endtask

  task automatic t_defer();
    int gap;
    wr(CTRL, 8'h04);
    wait_apply();
    while (!sys_tick) @(negedge clk);
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; wr_addr = CTRL; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check(gear_pending == 1'b1, "R6 pending after write", gear_pending, 1);
    gap = 3;
    while (!sys_tick && gap < 100) begin @(negedge clk); gap++; end
    check(gap == 32, "R5 old period completes", gap, 32);
    check(gear_pending == 1'b0, "R6 cleared at wrap", gear_pending, 0);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sys_tick && gap < 100);
    check(gap == 2, "R5 new period", gap, 2);
  endtask

  task automatic t_reserved();
    int s, g, t;
    wr(CTRL, 8'h02);
    wait_apply();
    wr(CTRL, 8'h05);
    wait_apply();
    count_win(320, s, g, t);
    check(s == 40, "R7 code 5 ignored", s, 40);
    wr(CTRL, 8'h07);
    wait_apply();
    count_win(320, s, g, t);
    check(g == 80, "R7 code 7 ignored", g, 80);
  endtask

  task automatic t_upper();
    int s, g, t;
    wr(CTRL, 8'hF1);
    wait_apply();
    count_win(320, s, g, t);
    check(s == 80, "R8 upper bits ignored", s, 80);
  endtask

  task automatic t_slow();
    int s, g, t;
    wr(CTRL, 8'h08);
    wait_apply();
    count_win(192, s, g, t);
    check(s == 32, "R2 slow gear 0", s, 32);
    wr(CTRL, 8'h0A);
    wait_apply();
    count_win(192, s, g, t);
    check(s == 8, "R2 slow gear 2 sys", s, 8);
    check(g == 16, "R2 slow gear 2 gear", g, 16);
    wr(CTRL, 8'h00);
    wait_apply();
  endtask

  task automatic t_pin();
    int s, g, t;
    wr(PINR, 8'h02);
    repeat (3) @(negedge clk);
    count_win(192, s, g, t);
    check(t == 64, "R10 pin follows slow", t, 64);
    wr(PINR, 8'h03);
    repeat (3) @(negedge clk);
    count_win(320, s, g, t);
    check(t == 160, "R10 pin follows sys", t, 160);
  endtask

  task automatic t_power();
    int s, g, t;
    pwr_mode = 2'b10;
    repeat (2) @(negedge clk);
    count_win(100, s, g, t);
    check(t == 0, "R11 deep mode 10 frozen", t, 0);
    pwr_mode = 2'b11;
    repeat (2) @(negedge clk);
    count_win(100, s, g, t);
    check(t == 0, "R11 deep mode 11 frozen", t, 0);
    pwr_mode = 2'b01;
    repeat (2) @(negedge clk);
    count_win(320, s, g, t);
    check(t == 160, "R11 light halt toggles", t, 160);
    pwr_mode = 2'b00;
  endtask

  task automatic t_disable();
    int s, g, t;
    wr(PINR, 8'h01);
    repeat (2) @(negedge clk);
    check(clk_out == 1'b0, "R9 disabled pin low", clk_out, 0);
    count_win(100, s, g, t);
    check(t == 0, "R9 disabled pin quiet", t, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gear_rates();
    t_defer();
    t_reserved();
    t_upper();
    t_slow();
    t_pin();
    t_power();
    t_disable();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule